// File: doc/BRIEF.md
# Two-Wire Bus Condition Front End

This block sits between the raw clock and data pins of a two-wire bus slave and the byte-level controller behind it. Everything runs in one system clock domain. Each raw line first passes through a two-flop synchroniser. It then goes through a run-length filter, which accepts a new level only after the line has held that level for a set number of system clock cycles. Pulses shorter than the spike limit therefore never reach the event logic.

The event logic watches the filtered lines and reports four kinds of event, each as a one-cycle strobe:
- a start strobe, when data falls while the clock stays high;
- a stop strobe, when data rises while the clock stays high;
- a sample strobe on every clock rise, carrying the data level seen at that moment;
- a strobe on every clock fall.

When the bus is idle, both lines are high.

On the return path the controller states, through a level input, whether it wants the data line pulled low. The block drives the line only as an open-drain enable. It applies the controller's request only once a hold window has passed after a clock fall. Its own output changes therefore always land well inside the low phase of the clock, where they cannot be read as start or stop. If the clock rises before the window expires, the pending update is dropped.

Top module: `twb_front`

## Requirements
- R1: After reset, all strobes are low and `sdaOe` is 0 (line released); the filtered lines start high, so releasing reset with both lines high produces no event.
- R2: A filtered fall of SDA while filtered SCL is high, and was high the cycle before, produces exactly one `startStb` and no sample strobe.
- R3: A filtered rise of SDA while filtered SCL is high, and was high the cycle before, produces exactly one `stopStb` and no sample strobe.
- R4: Each filtered rise of SCL produces exactly one `riseStb`, with `bitVal` equal to the filtered SDA level at that rise (1 = high), held until the next rise.
- R5: Each filtered fall of SCL produces exactly one `fallStb`; SDA changes while SCL is low produce no strobe at all.
- R6: A level on either raw line that lasts fewer than `FILT_CYC` consecutive system cycles is ignored; a level lasting exactly `FILT_CYC` cycles is accepted.
- R7: Every strobe is one cycle wide, and at most one of `startStb`, `stopStb`, `riseStb` and `fallStb` is high in any cycle.
- R8: `sdaOe` takes the value of `driveLow` exactly `HOLD_CYC` cycles after the cycle in which `fallStb` is high, and at no other time; `sdaOe` = 1 means the line is pulled low, and the block has no way to drive it high. Releasing the line this way is never reported as a stop.
- R9: If SCL rises before the hold window after a fall has run out, the pending update is dropped and `sdaOe` keeps its value until the next fall plus the full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line (wired level, including this block's own pull) |
| driveLow | input | 1 | Controller request: 1 = pull data low after the next hold window |
| startStb | output | 1 | One-cycle start condition strobe |
| stopStb | output | 1 | One-cycle stop condition strobe |
| riseStb | output | 1 | One-cycle strobe on each clock rise |
| bitVal | output | 1 | Data level sampled at the last clock rise |
| fallStb | output | 1 | One-cycle strobe on each clock fall |
| sdaOe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The bench aims spike pulses one cycle below and exactly at the filter length on both lines. A filter that is off by one either lets a runt pulse through as a false start or clock edge, or drops a legal pulse. It measures the exact gap between the fall strobe and each `sdaOe` change, including a low phase cut short by an early clock rise. A design that updates the output immediately, or that lets an aborted window fire later, would change data while the clock is high and create a false start or stop. It also loops the block's own pull back onto the data input, so that a release read as a stop, or a wrong sampled bit, is counted against the event totals.

// File: rtl/twb_pkg.sv
package twb_pkg;
  // Index of each line in the conditioned vector
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int LINE_CNT = 2;

  // Edge information passed from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic sdaRise;
    logic sdaFall;
    logic sclHigh;  // SCL high now and in the previous cycle
    logic sdaLvl;   // current filtered SDA level
  } twbEdges_t;
endpackage

// File: rtl/twb_line_cond.sv
module twb_line_cond #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      lvl    <= 1'b1;
      runCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == lvl) begin
        runCnt <= '0;
      end else if (runCnt == LAST) begin
        lvl    <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/twb_datapath.sv
module twb_datapath
  import twb_pkg::*;
#(
  parameter int FILT_CYC = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output twbEdges_t edges
);
  logic [LINE_CNT-1:0] rawVec;
  logic [LINE_CNT-1:0] fltVec;
  logic [LINE_CNT-1:0] prevVec;

  assign rawVec[LINE_SCL] = sclIn;
  assign rawVec[LINE_SDA] = sdaIn;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    twb_line_cond #(.FILT_CYC(FILT_CYC)) i_cond (
      .clk  (clk),
      .rstN (rstN),
      .rawIn(rawVec[g]),
      .lvl  (fltVec[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= '1;
    else       prevVec <= fltVec;
  end

  always_comb begin
    edges.sclRise = fltVec[LINE_SCL] & ~prevVec[LINE_SCL];
    edges.sclFall = ~fltVec[LINE_SCL] & prevVec[LINE_SCL];
    edges.sdaRise = fltVec[LINE_SDA] & ~prevVec[LINE_SDA];
    edges.sdaFall = ~fltVec[LINE_SDA] & prevVec[LINE_SDA];
    edges.sclHigh = fltVec[LINE_SCL] & prevVec[LINE_SCL];
    edges.sdaLvl  = fltVec[LINE_SDA];
  end
endmodule

// File: rtl/twb_control.sv
module twb_control
  import twb_pkg::*;
#(
  parameter int HOLD_CYC = 75
) (
  input  logic      clk,
  input  logic      rstN,
  input  twbEdges_t edges,
  input  logic      driveLow,
  output logic      startStb,
  output logic      stopStb,
  output logic      riseStb,
  output logic      bitVal,
  output logic      fallStb,
  output logic      sdaOe
);
  localparam int HCW = $clog2(HOLD_CYC + 1);
  localparam logic [HCW-1:0] HOLD_LOAD = HCW'(HOLD_CYC);

  logic [HCW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startStb <= 1'b0;
      stopStb  <= 1'b0;
      riseStb  <= 1'b0;
      fallStb  <= 1'b0;
      bitVal   <= 1'b0;
    end else begin
      startStb <= edges.sdaFall & edges.sclHigh;
      stopStb  <= edges.sdaRise & edges.sclHigh;
      riseStb  <= edges.sclRise;
      fallStb  <= edges.sclFall;
      if (edges.sclRise) bitVal <= edges.sdaLvl;
    end
  end

  // Output hold window: sdaOe moves only when the window after a fall runs out
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      sdaOe   <= 1'b0;
    end else if (edges.sclRise) begin
      holdCnt <= '0;
    end else if (edges.sclFall) begin
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - HCW'(1);
      if (holdCnt == HCW'(1)) sdaOe <= driveLow;
    end
  end
endmodule

// File: rtl/twb_front.sv
module twb_front
  import twb_pkg::*;
#(
  parameter int FILT_CYC = 13,
  parameter int HOLD_CYC = 75
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic driveLow,
  output logic startStb,
  output logic stopStb,
  output logic riseStb,
  output logic bitVal,
  output logic fallStb,
  output logic sdaOe
);
  twbEdges_t edges;

  twb_datapath #(.FILT_CYC(FILT_CYC)) i_datapath (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .edges(edges)
  );

  twb_control #(.HOLD_CYC(HOLD_CYC)) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .edges   (edges),
    .driveLow(driveLow),
    .startStb(startStb),
    .stopStb (stopStb),
    .riseStb (riseStb),
    .bitVal  (bitVal),
    .fallStb (fallStb),
    .sdaOe   (sdaOe)
  );
endmodule

// File: rtl/twb_front_chk.sv
module twb_front_chk #(
  parameter int HOLD_CYC = 75
) (
  input logic clk,
  input logic rstN,
  input logic startStb,
  input logic stopStb,
  input logic riseStb,
  input logic fallStb,
  input logic sdaOe
);
  localparam int SCW = $clog2(HOLD_CYC + 2);
  localparam logic [SCW-1:0] IDLE_VAL = SCW'(HOLD_CYC + 1);

  // Cycles since the last fall strobe; parked at IDLE_VAL when no window is open
  logic [SCW-1:0] sinceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      sinceFall <= IDLE_VAL;
    else if (fallStb)               sinceFall <= SCW'(1);
    else if (riseStb)               sinceFall <= IDLE_VAL;
    else if (sinceFall != IDLE_VAL) sinceFall <= sinceFall + SCW'(1);
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({startStb, stopStb, riseStb, fallStb}) <= 1); // R7

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> !startStb); // R7

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb); // R7

  AST_OE_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (sinceFall == SCW'(HOLD_CYC))); // R8

  AST_START_NOT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> !riseStb); // R2
endmodule

bind twb_front twb_front_chk #(.HOLD_CYC(HOLD_CYC)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startStb(startStb),
  .stopStb (stopStb),
  .riseStb (riseStb),
  .fallStb (fallStb),
  .sdaOe   (sdaOe)
);

// File: tb/test_twb_front.sv
`timescale 1ns/1ps
module test_twb_front;
  localparam int FILT = 13;
  localparam int HOLD = 75;
  localparam int NV   = 10;
  // Vector bits: [6] scl, [5] sda, [4] exp start, [3] exp stop,
  //              [2] exp rise, [1] exp fall, [0] exp sampled bit
  localparam logic [6:0] VEC [NV] = '{
    7'b1010000, // START
    7'b0000010, // SCL falls
    7'b0100000, // SDA rises while SCL low: nothing
    7'b1100101, // SCL rises, bit 1
    7'b0100010, // SCL falls
    7'b0000000, // SDA falls while SCL low: nothing
    7'b1000100, // SCL rises, bit 0
    7'b1101000, // STOP
    7'b1010000, // START
    7'b1101000  // STOP right after START
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, driveLow = 1'b0;
  logic sdaIn;
  logic startStb, stopStb, riseStb, bitVal, fallStb, sdaOe;

  assign sdaIn = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  twb_front #(.FILT_CYC(FILT), .HOLD_CYC(HOLD)) i_twb_front (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .driveLow(driveLow),
    .startStb(startStb), .stopStb(stopStb), .riseStb(riseStb), .bitVal(bitVal),
    .fallStb(fallStb), .sdaOe(sdaOe)
  );

  int checks = 0, errors = 0;
  int nStart = 0, nStop = 0, nRise = 0, nFall = 0, multiErr = 0;
  int sinceFall = 0, oeDelay = -1;
  logic lastBit = 1'b0, prevOe = 1'b0, prevAny = 1'b0;
  bit done = 0;

  // Event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (startStb) nStart++;
      if (stopStb)  nStop++;
      if (fallStb)  nFall++;
      if (riseStb) begin nRise++; lastBit = bitVal; end
      if ($countones({startStb, stopStb, riseStb, fallStb}) > 1) multiErr++;
      if (prevAny && (startStb || stopStb || riseStb || fallStb)) multiErr++;
      prevAny = startStb | stopStb | riseStb | fallStb;
      if (fallStb) sinceFall = 0; else sinceFall++;
      if (sdaOe != prevOe) oeDelay = sinceFall;
      prevOe = sdaOe;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int s0, p0, r0, f0;
    idle(3);
    chk("R1 sdaOe in reset", int'(sdaOe), 0);
    chk("R1 strobes in reset", int'({startStb, stopStb, riseStb, fallStb}), 0);
    rstN = 1'b1;
    idle(40);
    chk("R1 no event after reset", nStart + nStop + nRise + nFall, 0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      s0 = nStart; p0 = nStop; r0 = nRise; f0 = nFall;
      sclM = v[6]; sdaM = v[5];
      idle(40);
      chk($sformatf("R2 start vec %0d", i), nStart - s0, int'(v[4]));
      chk($sformatf("R3 stop vec %0d", i), nStop - p0, int'(v[3]));
      chk($sformatf("R4 rise vec %0d", i), nRise - r0, int'(v[2]));
      chk($sformatf("R5 fall vec %0d", i), nFall - f0, int'(v[1]));
      if (v[2]) chk($sformatf("R4 bit vec %0d", i), int'(lastBit), int'(v[0]));
    end

    // R6: spike filter boundary on SDA (idle bus, a pass would be START)
    s0 = nStart; p0 = nStop;
    sdaM = 1'b0; idle(FILT - 1); sdaM = 1'b1; idle(40);
    chk("R6 short SDA pulse start", nStart - s0, 0);
    chk("R6 short SDA pulse stop", nStop - p0, 0);
    sdaM = 1'b0; idle(FILT); sdaM = 1'b1; idle(40);
    chk("R6 full SDA pulse start", nStart - s0, 1);
    chk("R6 full SDA pulse stop", nStop - p0, 1);
    // R6: spike filter boundary on SCL
    r0 = nRise; f0 = nFall;
    sclM = 1'b0; idle(FILT - 1); sclM = 1'b1; idle(40);
    chk("R6 short SCL pulse fall", nFall - f0, 0);
    chk("R6 short SCL pulse rise", nRise - r0, 0);
    sclM = 1'b0; idle(FILT); sclM = 1'b1; idle(40);
    chk("R6 full SCL pulse fall", nFall - f0, 1);
    chk("R6 full SCL pulse rise", nRise - r0, 1);

    // R8: output hold window with loopback
    sdaM = 1'b0; idle(40);             // START
    driveLow = 1'b1; idle(40);
    chk("R8 no change while SCL high", int'(sdaOe), 0);
    oeDelay = -1;
    sclM = 1'b0; idle(120);
    chk("R8 pull applied", int'(sdaOe), 1);
    chk("R8 pull delay", oeDelay, HOLD);
    sdaM = 1'b1;                       // master releases, block still pulls
    p0 = nStop;
    sclM = 1'b1; idle(40);
    chk("R4 looped-back bit", int'(lastBit), 0);
    driveLow = 1'b0; idle(40);
    chk("R8 release deferred while SCL high", int'(sdaOe), 1);
    oeDelay = -1;
    sclM = 1'b0; idle(120);
    chk("R8 release applied", int'(sdaOe), 0);
    chk("R8 release delay", oeDelay, HOLD);
    chk("R8 release not a stop", nStop - p0, 0);

    // R9: window cut short by an early SCL rise
    driveLow = 1'b1;
    sclM = 1'b1; idle(40);
    sclM = 1'b0; idle(40);
    sclM = 1'b1; idle(200);
    chk("R9 aborted window keeps output", int'(sdaOe), 0);
    oeDelay = -1;
    sclM = 1'b0; idle(120);
    chk("R9 next full window applies", int'(sdaOe), 1);
    chk("R9 next window delay", oeDelay, HOLD);
    driveLow = 1'b0;
    sclM = 1'b1; idle(40);
    sclM = 1'b0; idle(120);
    chk("R8 final release", int'(sdaOe), 0);

    chk("R7 strobe width and overlap", multiErr, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule